// File: doc/BRIEF.md
# Condition-Code Branch Sequencing Unit

This block owns the program counter of a 16-bit, word-addressed processor, together with a three-flag condition-code register. It decides which address is executed next. The flags record the sign class of the most recent value written to a register: negative, zero or strictly positive. Exactly one of the three flags is set at all times.

Each instruction step presents one instruction word. The PC first advances by one word. The next PC is then chosen as follows:

- A conditional branch adds a signed 9-bit offset to the advanced PC when its three-bit mask selects a flag that is currently set.
- A register jump loads the full contents of a general register.
- A trap loads a service-routine address read from a vector table in the low 256 words. It also asks the register file to store the return address in the link register.

Instruction fetch, memory, the ALU and the register file are outside the block. The block drives the register-read select and the vector-table address, and it receives the read results combinationally in the same step.

Top module: `cbs_branch_seq`

## Requirements
- R1: After reset the PC equals the parameter START_PC and the flags hold zero (a branch with mask 010 is taken and masks 100 and 001 are not).
- R2: When wb_valid is high at a clock edge, the flags become negative if wb_data[15] is 1, zero if wb_data is 0, and positive otherwise; exactly one flag is ever set.
- R3: When wb_valid is low the flags keep their value.
- R4: A branch (opcode bits [15:12] = 0000, mask in bits [11:9] ordered negative, zero, positive from MSB) whose mask selects a set flag asserts redirect and loads PC+1 plus the sign-extended bits [8:0].
- R5: A branch whose mask selects no set flag leaves redirect low and loads PC+1; mask 000 is never taken.
- R6: A branch with mask 111 is always taken.
- R7: A jump (opcode 1100) drives rd_sel with bits [8:6], asserts redirect and loads rd_data into the PC.
- R8: A trap (opcode 1111) drives vec_addr with bits [7:0] zero-extended, loads vec_data into the PC, asserts redirect, and raises link_we with link_sel = 7 and link_data = PC+1.
- R9: Any other opcode loads PC+1 with redirect and link_we low.
- R10: While step_en is low the PC holds, and redirect and link_we stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | An instruction is presented this cycle |
| instr | input | 16 | Current instruction word |
| wb_valid | input | 1 | A register value is being written this cycle |
| wb_data | input | 16 | Value being written, sets the flags |
| rd_sel | output | 3 | Register-read select for the jump base |
| rd_data | input | 16 | Register-read result |
| vec_addr | output | 16 | Vector-table read address |
| vec_data | input | 16 | Vector-table read result |
| pc | output | 16 | Program counter |
| link_we | output | 1 | Link-register write request |
| link_sel | output | 3 | Link-register index (always 7) |
| link_data | output | 16 | Return address |
| redirect | output | 1 | Control flow leaves the sequential path |

## Verification
The assertions assume that rd_data and vec_data are settled, combinational responses to rd_sel and vec_addr within the same cycle. They also assume that write-backs may arrive in any cycle, independent of step_en. The stimulus drives all inputs on the falling edge and holds them stable across the rising edge. It draws register and table values at random for every step. This means the jump and trap targets used by the checks are exactly the values present at the capturing edge.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned OFF_W  = 9;
  localparam int unsigned VEC_W  = 8;
  localparam int unsigned RSEL_W = 3;

  localparam logic [3:0] OPC_BR   = 4'b0000;
  localparam logic [3:0] OPC_JREG = 4'b1100;
  localparam logic [3:0] OPC_TRAP = 4'b1111;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    K_SEQ  = 2'd0,
    K_BR   = 2'd1,
    K_JREG = 2'd2,
    K_TRAP = 2'd3
  } kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic p;
  } cc_t;

  typedef struct packed {
    kind_e             kind;
    logic [2:0]        mask;
    word_t             off;
    logic [RSEL_W-1:0] base;
    word_t             vec;
  } dec_t;
endpackage

// File: rtl/cbs_rst_sync.sv
module cbs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sh_q[STAGES-1];
endmodule

// File: rtl/cbs_decode.sv
module cbs_decode
  import cbs_pkg::*;
(
  input  word_t instr,
  output dec_t  dec
);
  always_comb begin
    dec.mask = instr[11:9];
    dec.off  = {{(WORD_W-OFF_W){instr[OFF_W-1]}}, instr[OFF_W-1:0]};
    dec.base = instr[8:6];
    dec.vec  = {{(WORD_W-VEC_W){1'b0}}, instr[VEC_W-1:0]};
    unique case (instr[15:12])
      OPC_BR:   dec.kind = K_BR;
      OPC_JREG: dec.kind = K_JREG;
      OPC_TRAP: dec.kind = K_TRAP;
      default:  dec.kind = K_SEQ;
    endcase
  end
endmodule

// File: rtl/cbs_ccreg.sv
module cbs_ccreg
  import cbs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wb_valid,
  input  word_t wb_data,
  output cc_t   cc
);
  cc_t cc_q, cc_d, cc_new;

  always_comb begin
    cc_new.n = wb_data[WORD_W-1];
    cc_new.z = (wb_data == '0);
    cc_new.p = !wb_data[WORD_W-1] && (wb_data != '0);
  end

  always_comb begin
    cc_d = cc_q;
    if (wb_valid) cc_d = cc_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cc_q <= '{n: 1'b0, z: 1'b1, p: 1'b0};
    else        cc_q <= cc_d;
  end

  assign cc = cc_q;
endmodule

// File: rtl/cbs_nextpc.sv
module cbs_nextpc
  import cbs_pkg::*;
(
  input  logic  step_en,
  input  dec_t  dec,
  input  cc_t   cc,
  input  word_t pc,
  input  word_t rd_data,
  input  word_t vec_data,
  output word_t pc_nxt,
  output logic  redirect,
  output logic  link_we,
  output word_t link_data
);
  word_t pc_inc;
  word_t br_tgt;
  logic  cond_hit;

  assign pc_inc   = pc + word_t'(1);
  assign br_tgt   = pc_inc + dec.off;
  assign cond_hit = |(dec.mask & {cc.n, cc.z, cc.p});

  always_comb begin
    pc_nxt    = pc;
    redirect  = 1'b0;
    link_we   = 1'b0;
    link_data = pc_inc;
    if (step_en) begin
      pc_nxt = pc_inc;
      unique case (dec.kind)
        K_BR: begin
          if (cond_hit) begin
            pc_nxt   = br_tgt;
            redirect = 1'b1;
          end
        end
        K_JREG: begin
          pc_nxt   = rd_data;
          redirect = 1'b1;
        end
        K_TRAP: begin
          pc_nxt   = vec_data;
          redirect = 1'b1;
          link_we  = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cbs_branch_seq.sv
module cbs_branch_seq
  import cbs_pkg::*;
#(
  parameter logic [15:0] START_PC = 16'h3000,
  parameter int unsigned LINK_REG = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step_en,
  input  logic [15:0] instr,
  input  logic        wb_valid,
  input  logic [15:0] wb_data,
  output logic [2:0]  rd_sel,
  input  logic [15:0] rd_data,
  output logic [15:0] vec_addr,
  input  logic [15:0] vec_data,
  output logic [15:0] pc,
  output logic        link_we,
  output logic [2:0]  link_sel,
  output logic [15:0] link_data,
  output logic        redirect
);
  logic  rst_q_n;
  dec_t  dec;
  cc_t   cc;
  word_t pc_q, pc_d;

  cbs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  cbs_decode u_dec (.instr(instr), .dec(dec));

  cbs_ccreg u_cc (
    .clk(clk), .rst_n(rst_q_n), .wb_valid(wb_valid),
    .wb_data(wb_data), .cc(cc)
  );

  cbs_nextpc u_np (
    .step_en(step_en), .dec(dec), .cc(cc), .pc(pc_q),
    .rd_data(rd_data), .vec_data(vec_data), .pc_nxt(pc_d),
    .redirect(redirect), .link_we(link_we), .link_data(link_data)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)     pc_q <= START_PC;
    else if (step_en) pc_q <= pc_d;
  end

  assign pc       = pc_q;
  assign rd_sel   = dec.base;
  assign vec_addr = dec.vec;
  assign link_sel = 3'(LINK_REG);
endmodule

// File: rtl/cbs_branch_seq_chk.sv
module cbs_branch_seq_chk
  import cbs_pkg::*;
(
  input logic        clk,
  input logic        rst_q_n,
  input logic        step_en,
  input logic [15:0] instr,
  input logic        wb_valid,
  input logic [15:0] wb_data,
  input logic [15:0] rd_data,
  input logic [15:0] pc,
  input logic        link_we,
  input logic [2:0]  link_sel,
  input logic [15:0] link_data,
  input logic        redirect,
  input cc_t         cc
);
  p_flags_onehot_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    $countones({cc.n, cc.z, cc.p}) == 1);

  p_flags_hold_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    !wb_valid |=> $stable(cc));

  p_seq_step_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (step_en && !redirect) |=> pc == $past(pc) + 16'd1);

  p_mask_none_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (step_en && instr[15:12] == OPC_BR && instr[11:9] == 3'b000) |-> !redirect);

  p_mask_all_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (step_en && instr[15:12] == OPC_BR && instr[11:9] == 3'b111) |-> redirect);

  p_jump_tgt_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (step_en && instr[15:12] == OPC_JREG) |=> pc == $past(rd_data));

  p_link_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    link_we |-> (step_en && link_sel == 3'd7 && link_data == pc + 16'd1));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !step_en |=> $stable(pc));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !step_en |-> (!redirect && !link_we));
endmodule

bind cbs_branch_seq cbs_branch_seq_chk u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .step_en(step_en), .instr(instr),
  .wb_valid(wb_valid), .wb_data(wb_data), .rd_data(rd_data), .pc(pc),
  .link_we(link_we), .link_sel(link_sel), .link_data(link_data),
  .redirect(redirect), .cc(cc)
);

// File: tb/tb_cbs_branch_seq.sv
module tb_cbs_branch_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] START = 16'h3000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_en;
  logic [15:0] instr;
  logic        wb_valid;
  logic [15:0] wb_data;
  logic [2:0]  rd_sel;
  logic [15:0] rd_data;
  logic [15:0] vec_addr;
  logic [15:0] vec_data;
  logic [15:0] pc;
  logic        link_we;
  logic [2:0]  link_sel;
  logic [15:0] link_data;
  logic        redirect;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_pc;
  logic [2:0]  m_cc;
  bit done = 0;

  cbs_branch_seq #(.START_PC(START)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [2:0] cc_of(input logic [15:0] v);
    if (v[15])      return 3'b100;
    else if (v == 0) return 3'b010;
    else            return 3'b001;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input string req, input logic en, input logic [15:0] ins,
                      input logic wv, input logic [15:0] wd,
                      input logic [15:0] rd, input logic [15:0] vd);
    logic [15:0] inc, e_pc;
    logic e_red, e_lnk;
    logic [3:0] op;
    @(negedge clk);
    step_en = en; instr = ins; wb_valid = wv; wb_data = wd;
    rd_data = rd; vec_data = vd;
    #(CLK_PERIOD/4);
    op = ins[15:12]; inc = m_pc + 16'd1;
    e_pc = m_pc; e_red = 0; e_lnk = 0;
    if (en) begin
      e_pc = inc;
      if (op == 4'b0000 && (ins[11:9] & m_cc) != 0) begin
        e_pc = inc + {{7{ins[8]}}, ins[8:0]}; e_red = 1;
      end else if (op == 4'b1100) begin
        e_pc = rd; e_red = 1;
      end else if (op == 4'b1111) begin
        e_pc = vd; e_red = 1; e_lnk = 1;
      end
    end
    chk({req, " redirect"}, 32'(redirect), 32'(e_red));
    chk({req, " link_we"}, 32'(link_we), 32'(e_lnk));
    if (en && op == 4'b1100) chk("R7 rd_sel", 32'(rd_sel), 32'(ins[8:6]));
    if (en && op == 4'b1111) begin
      chk("R8 vec_addr", 32'(vec_addr), {24'h0, ins[7:0]});
      chk("R8 link", {13'h0, link_sel, link_data}, {13'h0, 3'd7, inc});
    end
    @(posedge clk);
    #1;
    m_pc = e_pc;
    if (wv) m_cc = cc_of(wd);
    chk({req, " pc"}, 32'(pc), 32'(m_pc));
  endtask

  function automatic logic [15:0] br(input logic [2:0] m, input logic [8:0] o);
    return {4'b0000, m, o};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; step_en = 0; instr = 0; wb_valid = 0; wb_data = 0;
    rd_data = 0; vec_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    m_pc = START; m_cc = 3'b010;
    chk("R1 reset pc", 32'(pc), 32'(START));
    // R1: reset flags are zero
    step("R1 mask100", 1, br(3'b100, 9'h005), 0, 0, 0, 0);
    step("R1 mask001", 1, br(3'b001, 9'h005), 0, 0, 0, 0);
    step("R1 mask010", 1, br(3'b010, 9'h005), 0, 0, 0, 0);
    // R5: mask 000 never taken
    step("R5 mask000", 1, br(3'b000, 9'h0ff), 0, 0, 0, 0);
    // R6: mask 111 always taken, negative offset
    step("R6 mask111", 1, br(3'b111, 9'h1fc), 0, 0, 0, 0);
    // R2: negative value, then branch on n
    step("R2 wb neg", 0, 16'h0000, 1, 16'h8000, 0, 0);
    step("R2 n taken", 1, br(3'b100, 9'h100), 0, 0, 0, 0);
    step("R2 wb pos", 0, 16'h0000, 1, 16'h0001, 0, 0);
    step("R4 p taken", 1, br(3'b011, 9'h0ff), 0, 0, 0, 0);
    // R3: flags held when wb_valid low
    step("R3 hold", 1, 16'h1234, 0, 16'h0000, 0, 0);
    step("R3 p still", 1, br(3'b001, 9'h002), 0, 0, 0, 0);
    step("R5 z not", 1, br(3'b110, 9'h002), 0, 0, 0, 0);
    step("R7 jump", 1, {4'b1100, 3'b000, 3'b101, 6'b0}, 0, 0, 16'hbeef, 0);
    step("R8 trap", 1, {4'b1111, 4'b0, 8'h25}, 0, 0, 0, 16'h0400);
    step("R9 other", 1, 16'h5020, 0, 0, 0, 0);
    step("R10 idle", 0, {4'b1111, 4'b0, 8'h21}, 0, 0, 16'h1111, 16'h2222);
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] ins;
      logic [1:0] sel;
      sel = 2'($urandom_range(0, 3));
      ins = 16'($urandom);
      case (sel)
        2'd0: ins[15:12] = 4'b0000;
        2'd1: ins[15:12] = 4'b1100;
        2'd2: ins[15:12] = 4'b1111;
        default: ;
      endcase
      step("R4 rand", ($urandom_range(0, 7) != 0), ins,
           ($urandom_range(0, 1) == 1),
           ($urandom_range(0, 5) == 0) ? 16'h0000 : 16'($urandom),
           16'($urandom), 16'($urandom));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule